// File: doc/BRIEF.md
# Byte Register ALU Execution Unit

This unit executes the register-with-accumulator instruction group of a small 8-bit accumulator machine. Each accepted 14-bit instruction word names an operation, a destination select and one of 128 registers in a file held inside the unit. The unit reads that register and combines it with the accumulator: add, subtract, decrement, AND, XOR or inclusive OR. It then writes the byte result to the accumulator or back to the register, and updates only the status flags the operation owns.

A decrement variant tests its result for zero. When the result is zero, the unit signals that the following instruction is to be skipped and stalls its input for one cycle. The surrounding core loads registers and the accumulator through separate write ports, which stand in for the instruction groups outside this unit. A read port shows any register's contents. Words outside the group raise an illegal-operation pulse and leave all state alone.

Top module: `byte_alu_exec`

## Requirements
- R1: An instruction word is decoded as bits [13:12] = 2'b01 (group), [11:8] = operation code, [7] = destination select, [6:0] = register index.
- R2: With destination select 0 the result is written to the accumulator and the register is unchanged; with select 1 the result is written to the register and the accumulator is unchanged.
- R3: Code 4'b0110 produces register minus one (mod 256) and updates Z only.
- R4: Code 4'b0111 produces register minus one and updates no flag. When its result is zero, in the cycle after acceptance skip_o is 1 and ready_o is 0, and both return to their idle values one cycle later.
- R5: Code 4'b0101 produces register plus accumulator. C is the carry out of bit 7 and DC the carry out of bit 3.
- R6: Code 4'b1010 produces register minus accumulator. C is 1 when no borrow out of bit 7 occurs, and DC is 1 when no borrow out of bit 3 occurs.
- R7: Codes 4'b0100 (AND), 4'b1011 (XOR) and 4'b1111 (inclusive OR) combine register and accumulator bitwise, update Z, and leave C and DC unchanged.
- R8: Whenever Z is updated, it becomes 1 exactly when the 8-bit result is zero.
- R9: A word whose group bits are not 2'b01, or whose code is not listed above, makes illegal_o 1 for one cycle and changes no register, accumulator or flag.
- R10: An instruction is accepted on a rising clock edge when valid_i and ready_o are both 1. Its results are visible on the outputs right after that edge, and ready_o is 1 at all times except the stall cycle of R4.
- R11: After reset the accumulator, all flags and every register are zero, ready_o is 1, and skip_o and illegal_o are 0.
- R12: reg_we_i loads reg_wdata_i into register reg_waddr_i, and acc_we_i loads acc_wdata_i into the accumulator, at the next edge. An accepted instruction's write-back to the same target in that cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Instruction word present |
| instr_i | input | 14 | Instruction word |
| ready_o | output | 1 | Unit can accept an instruction |
| reg_we_i | input | 1 | External register load enable |
| reg_waddr_i | input | 7 | External register load index |
| reg_wdata_i | input | 8 | External register load data |
| acc_we_i | input | 1 | External accumulator load enable |
| acc_wdata_i | input | 8 | External accumulator load data |
| rd_addr_i | input | 7 | Register read-out index |
| rd_data_o | output | 8 | Register read-out data |
| acc_o | output | 8 | Accumulator |
| flag_z_o | output | 1 | Zero flag |
| flag_c_o | output | 1 | Carry / no-borrow flag |
| flag_dc_o | output | 1 | Nibble carry / no-borrow flag |
| skip_o | output | 1 | Next instruction is skipped (stall cycle) |
| illegal_o | output | 1 | Previous accepted word was not in the group |

## Verification
The bench checks the boundaries of carry and borrow. Sums of 0x0F+0x01 and 0xFF+0x01 test the nibble and byte carries, and differences such as 3-5, 0x10-0x01 and equal operands test the no-borrow sense. A design with inverted borrow polarity or a nibble carry taken at the wrong bit would get these wrong. The decrement-and-skip form is run on 1, 2 and 0: a unit that touches flags, skips on a non-zero result or fails to stall would be caught. Bitwise operations run with C and DC set beforehand, which exposes flag clobbering. Illegal words with a bad code or a bad group must leave all state intact. A long pseudo-random run compares every result and flag against a behavioural model.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;
  localparam logic [1:0] GRP_REG_ALU = 2'b01;

  typedef enum logic [3:0] {
    OP_AND   = 4'b0100,
    OP_ADD   = 4'b0101,
    OP_DEC   = 4'b0110,
    OP_DECSZ = 4'b0111,
    OP_SUB   = 4'b1010,
    OP_XOR   = 4'b1011,
    OP_IOR   = 4'b1111
  } alu_op_e;

  typedef struct packed {
    logic legal;
    logic wr_z;
    logic wr_cdc;
    logic skip_op;
  } alu_ctl_t;
endpackage

// File: rtl/byte_alu_regfile.sv
module byte_alu_regfile #(
  parameter int DW = 8,
  parameter int AW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          core_we_i,
  input  logic [AW-1:0] core_waddr_i,
  input  logic [DW-1:0] core_wdata_i,
  input  logic          ext_we_i,
  input  logic [AW-1:0] ext_waddr_i,
  input  logic [DW-1:0] ext_wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [DW-1:0] rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [DW-1:0] rdata_b_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic hit_core, hit_ext;
    assign hit_core = core_we_i && (core_waddr_i == AW'(g));
    assign hit_ext  = ext_we_i  && (ext_waddr_i  == AW'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       mem_q[g] <= '0;
      else if (hit_core) mem_q[g] <= core_wdata_i;
      else if (hit_ext)  mem_q[g] <= ext_wdata_i;
    end
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/byte_alu_core.sv
module byte_alu_core
  import byte_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [1:0]    grp_i,
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] reg_i,
  input  logic [DW-1:0] acc_i,
  output logic [DW-1:0] res_o,
  output logic          c_o,
  output logic          dc_o,
  output logic          z_o,
  output alu_ctl_t      ctl_o
);
  localparam int HW = DW / 2;

  logic [DW:0] add_full, sub_full, dec_full;
  logic [HW:0] add_lo, sub_lo;

  // subtraction as reg + ~acc + 1: carry out means no borrow
  assign add_full = {1'b0, reg_i} + {1'b0, acc_i};
  assign sub_full = {1'b0, reg_i} + {1'b0, ~acc_i} + {{DW{1'b0}}, 1'b1};
  assign dec_full = {1'b0, reg_i} - {{DW{1'b0}}, 1'b1};
  assign add_lo   = {1'b0, reg_i[HW-1:0]} + {1'b0, acc_i[HW-1:0]};
  assign sub_lo   = {1'b0, reg_i[HW-1:0]} + {1'b0, ~acc_i[HW-1:0]} + {{HW{1'b0}}, 1'b1};

  always_comb begin
    res_o = '0;
    c_o   = 1'b0;
    dc_o  = 1'b0;
    ctl_o = '0;
    if (grp_i == GRP_REG_ALU) begin
      unique case (op_i)
        OP_ADD: begin
          res_o = add_full[DW-1:0];
          c_o   = add_full[DW];
          dc_o  = add_lo[HW];
          ctl_o = '{legal: 1'b1, wr_z: 1'b1, wr_cdc: 1'b1, skip_op: 1'b0};
        end
        OP_SUB: begin
          res_o = sub_full[DW-1:0];
          c_o   = sub_full[DW];
          dc_o  = sub_lo[HW];
          ctl_o = '{legal: 1'b1, wr_z: 1'b1, wr_cdc: 1'b1, skip_op: 1'b0};
        end
        OP_DEC: begin
          res_o = dec_full[DW-1:0];
          ctl_o = '{legal: 1'b1, wr_z: 1'b1, wr_cdc: 1'b0, skip_op: 1'b0};
        end
        OP_DECSZ: begin
          res_o = dec_full[DW-1:0];
          ctl_o = '{legal: 1'b1, wr_z: 1'b0, wr_cdc: 1'b0, skip_op: 1'b1};
        end
        OP_AND: begin
          res_o = reg_i & acc_i;
          ctl_o = '{legal: 1'b1, wr_z: 1'b1, wr_cdc: 1'b0, skip_op: 1'b0};
        end
        OP_XOR: begin
          res_o = reg_i ^ acc_i;
          ctl_o = '{legal: 1'b1, wr_z: 1'b1, wr_cdc: 1'b0, skip_op: 1'b0};
        end
        OP_IOR: begin
          res_o = reg_i | acc_i;
          ctl_o = '{legal: 1'b1, wr_z: 1'b1, wr_cdc: 1'b0, skip_op: 1'b0};
        end
        default: ctl_o = '0;
      endcase
    end
  end

  assign z_o = (res_o == '0);
endmodule

// File: rtl/byte_alu_exec.sv
module byte_alu_exec
  import byte_alu_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 7,
  localparam int IW = 2 + 4 + 1 + AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [IW-1:0] instr_i,
  output logic          ready_o,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_waddr_i,
  input  logic [DW-1:0] reg_wdata_i,
  input  logic          acc_we_i,
  input  logic [DW-1:0] acc_wdata_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic [DW-1:0] acc_o,
  output logic          flag_z_o,
  output logic          flag_c_o,
  output logic          flag_dc_o,
  output logic          skip_o,
  output logic          illegal_o
);
  localparam int D_BIT = AW;
  localparam int OP_LO = AW + 1;

  logic [1:0]    grp;
  logic [3:0]    op;
  logic          dst_reg;
  logic [AW-1:0] raddr;
  logic [DW-1:0] reg_val, res;
  logic          res_c, res_dc, res_z;
  alu_ctl_t      ctl;
  logic          accept, exec, reg_wb;

  logic [DW-1:0] acc_q;
  logic          z_q, c_q, dc_q, stall_q, illegal_q;

  assign grp     = instr_i[IW-1 -: 2];
  assign op      = instr_i[OP_LO +: 4];
  assign dst_reg = instr_i[D_BIT];
  assign raddr   = instr_i[AW-1:0];

  assign ready_o = !stall_q;
  assign accept  = valid_i && ready_o;
  assign exec    = accept && ctl.legal;
  assign reg_wb  = exec && dst_reg;

  byte_alu_regfile #(.DW(DW), .AW(AW)) u_rf (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .core_we_i    (reg_wb),
    .core_waddr_i (raddr),
    .core_wdata_i (res),
    .ext_we_i     (reg_we_i),
    .ext_waddr_i  (reg_waddr_i),
    .ext_wdata_i  (reg_wdata_i),
    .raddr_a_i    (raddr),
    .rdata_a_o    (reg_val),
    .raddr_b_i    (rd_addr_i),
    .rdata_b_o    (rd_data_o)
  );

  byte_alu_core #(.DW(DW)) u_core (
    .grp_i (grp),
    .op_i  (op),
    .reg_i (reg_val),
    .acc_i (acc_q),
    .res_o (res),
    .c_o   (res_c),
    .dc_o  (res_dc),
    .z_o   (res_z),
    .ctl_o (ctl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= '0;
      z_q       <= 1'b0;
      c_q       <= 1'b0;
      dc_q      <= 1'b0;
      stall_q   <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= accept && !ctl.legal;
      stall_q   <= exec && ctl.skip_op && res_z;
      if (exec && !dst_reg) acc_q <= res;
      else if (acc_we_i)    acc_q <= acc_wdata_i;
      if (exec && ctl.wr_z) z_q <= res_z;
      if (exec && ctl.wr_cdc) begin
        c_q  <= res_c;
        dc_q <= res_dc;
      end
    end
  end

  assign acc_o     = acc_q;
  assign flag_z_o  = z_q;
  assign flag_c_o  = c_q;
  assign flag_dc_o = dc_q;
  assign skip_o    = stall_q;
  assign illegal_o = illegal_q;
endmodule

// File: rtl/byte_alu_exec_chk.sv
module byte_alu_exec_chk #(
  parameter int IW = 14
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [IW-1:0] instr_i,
  input logic          ready_o,
  input logic          acc_we_i,
  input logic [7:0]    acc_o,
  input logic          flag_z_o,
  input logic          flag_c_o,
  input logic          flag_dc_o,
  input logic          skip_o,
  input logic          illegal_o
);
  logic       acc_ok;
  logic [3:0] code;
  assign acc_ok = valid_i && ready_o && (instr_i[IW-1 -: 2] == 2'b01);
  assign code   = instr_i[IW-3 -: 4];

  a_r4_skip_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |-> (!ready_o && $past(acc_ok && code == 4'b0111)));

  a_r4_no_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_ok && code == 4'b0111) |=> $stable({flag_z_o, flag_c_o, flag_dc_o}));

  a_r7_keep_cdc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_ok && (code == 4'b0100 || code == 4'b1011 || code == 4'b1111))
      |=> $stable({flag_c_o, flag_dc_o}));

  a_r9_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (illegal_o && $past(!acc_we_i))
      |-> ($stable(acc_o) && $stable({flag_z_o, flag_c_o, flag_dc_o})));

  a_r9_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(illegal_o && skip_o));

  a_r10_ready_only_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> skip_o);
endmodule

bind byte_alu_exec byte_alu_exec_chk #(.IW(14)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .instr_i   (instr_i),
  .ready_o   (ready_o),
  .acc_we_i  (acc_we_i),
  .acc_o     (acc_o),
  .flag_z_o  (flag_z_o),
  .flag_c_o  (flag_c_o),
  .flag_dc_o (flag_dc_o),
  .skip_o    (skip_o),
  .illegal_o (illegal_o)
);

// File: tb/byte_alu_exec_tb.sv
module byte_alu_exec_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [13:0] instr_i = '0;
  logic       ready_o;
  logic       reg_we_i = 1'b0;
  logic [6:0] reg_waddr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic       acc_we_i = 1'b0;
  logic [7:0] acc_wdata_i = '0;
  logic [6:0] rd_addr_i = '0;
  logic [7:0] rd_data_o, acc_o;
  logic       flag_z_o, flag_c_o, flag_dc_o, skip_o, illegal_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_rf [128];
  int m_acc, m_z, m_c, m_dc;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  byte_alu_exec u_dut (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_sim();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic cmp_state(string req, int addr);
    rd_addr_i = 7'(addr);
    #1;
    chk({req, " acc"}, acc_o, m_acc);
    chk({req, " z"}, flag_z_o, m_z);
    chk({req, " c"}, flag_c_o, m_c);
    chk({req, " dc"}, flag_dc_o, m_dc);
    chk({req, " reg"}, rd_data_o, m_rf[addr]);
  endtask

  task automatic load_reg(int a, int v);
    reg_we_i = 1'b1; reg_waddr_i = 7'(a); reg_wdata_i = 8'(v);
    @(negedge clk_i);
    reg_we_i = 1'b0;
    m_rf[a] = v & 255;
  endtask

  task automatic load_acc(int v);
    acc_we_i = 1'b1; acc_wdata_i = 8'(v);
    @(negedge clk_i);
    acc_we_i = 1'b0;
    m_acc = v & 255;
  endtask

  // drive one instruction at a negedge; model it; check one cycle later
  task automatic run(string req, int grp, int op, int d, int r);
    int rv, res, legal, wz, wcdc, skip, c, dc;
    rv = m_rf[r]; legal = (grp == 1); wz = 1; wcdc = 0; skip = 0; c = 0; dc = 0; res = 0;
    case (op)
      4'b0101: begin res = rv + m_acc; c = res > 255; dc = ((rv & 15) + (m_acc & 15)) > 15; wcdc = 1; end
      4'b1010: begin res = rv - m_acc; c = rv >= m_acc; dc = (rv & 15) >= (m_acc & 15); wcdc = 1; end
      4'b0110: res = rv - 1;
      4'b0111: begin res = rv - 1; wz = 0; end
      4'b0100: res = rv & m_acc;
      4'b1011: res = rv ^ m_acc;
      4'b1111: res = rv | m_acc;
      default: legal = 0;
    endcase
    res = res & 255;
    chk({req, " ready before"}, ready_o, 1);
    valid_i = 1'b1;
    instr_i = {2'(grp), 4'(op), 1'(d), 7'(r)};
    @(negedge clk_i);
    valid_i = 1'b0;
    if (legal) begin
      if (d) m_rf[r] = res; else m_acc = res;
      if (wz) m_z = (res == 0);
      if (wcdc) begin m_c = c; m_dc = dc; end
      skip = (op == 4'b0111) && (res == 0);
    end
    cmp_state(req, r);
    chk({req, " illegal"}, illegal_o, !legal);
    chk({req, " skip"}, skip_o, skip);
    chk({req, " ready"}, ready_o, !skip);
    if (skip) begin
      @(negedge clk_i);
      chk({req, " skip release"}, skip_o, 0);
      chk({req, " ready release"}, ready_o, 1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_sim();
  end

  initial begin
    for (int i = 0; i < 128; i++) m_rf[i] = 0;
    m_acc = 0; m_z = 0; m_c = 0; m_dc = 0;
    #(CLK_PERIOD * 2);
    @(negedge clk_i);
    // R11 reset state
    cmp_state("R11", 0);
    cmp_state("R11", 127);
    chk("R11 ready", ready_o, 1);
    chk("R11 skip", skip_o, 0);
    chk("R11 illegal", illegal_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R12 loads
    load_reg(5, 8'h0F); load_acc(8'h01);
    cmp_state("R12", 5);
    // R5 nibble carry, R2 to acc
    run("R5 0F+01 R2", 1, 4'b0101, 0, 5);
    load_reg(6, 8'hFF); load_acc(8'h01);
    run("R5 FF+01 R8", 1, 4'b0101, 1, 6);
    // R6 borrow cases
    load_reg(7, 5); load_acc(5);
    run("R6 5-5", 1, 4'b1010, 1, 7);
    load_reg(7, 3);
    run("R6 3-5", 1, 4'b1010, 0, 7);
    load_reg(8, 8'h10); load_acc(1);
    run("R6 10-01", 1, 4'b1010, 1, 8);
    // R3 decrement
    load_reg(9, 1);
    run("R3 1->0", 1, 4'b0110, 1, 9);
    run("R3 0->FF", 1, 4'b0110, 1, 9);
    // R4 decrement-and-skip
    load_reg(10, 2);
    run("R4 noskip", 1, 4'b0111, 1, 10);
    run("R4 skip", 1, 4'b0111, 1, 10);
    run("R4 wrap", 1, 4'b0111, 0, 10);
    // R7 logic ops with C/DC set first
    load_reg(11, 8'hFF); load_acc(8'h01);
    run("R7 prep", 1, 4'b0101, 0, 11);
    load_reg(12, 8'hA5); load_acc(8'h5A);
    run("R7 and", 1, 4'b0100, 0, 12);
    load_acc(8'h5A);
    run("R7 xor", 1, 4'b1011, 1, 12);
    run("R7 ior", 1, 4'b1111, 0, 12);
    // R9 illegal code and group
    load_reg(13, 8'h33);
    run("R9 code", 1, 4'b0000, 1, 13);
    run("R9 group", 3, 4'b0101, 1, 13);
    run("R9 group0", 0, 4'b0110, 0, 13);
    // R12 precedence: instr write-back and ext load to same register
    load_reg(14, 4); load_acc(1);
    reg_we_i = 1'b1; reg_waddr_i = 7'd14; reg_wdata_i = 8'h77;
    run("R12 prec", 1, 4'b0101, 1, 14);
    reg_we_i = 1'b0;
    cmp_state("R12 prec after", 14);
    // R1 R10 random back-to-back
    for (int n = 0; n < 400; n++) begin
      int sel, ops[8];
      ops = '{4'b0101, 4'b1010, 4'b0110, 4'b0111, 4'b0100, 4'b1011, 4'b1111, 4'b0010};
      sel = $urandom_range(0, 7);
      if ($urandom_range(0, 4) == 0) load_reg($urandom_range(0, 127) & 7, $urandom_range(0, 255));
      if ($urandom_range(0, 4) == 0) load_acc($urandom_range(0, 255));
      run("R1 R10 rand", ($urandom_range(0, 9) == 0) ? 2 : 1, ops[sel],
          $urandom_range(0, 1), $urandom_range(0, 7));
    end
    finish_sim();
  end
endmodule